// File: doc/BRIEF.md
# Heater Power Ramp Sequencer

This block brings the applied heater power up to a requested level in equal stages, so that the supply never sees the full load switched on at once. Full scale is split into twenty stages of one twentieth each. A ramp begins whenever high power is enabled, including straight after reset with the enable already high. Between two stages the block waits a programmable number of microsecond ticks. The applied level is capped at the requested target, and the ramp ends as soon as the target is reached. From then on the output follows the target directly.

The spacing between stages is a 16-bit count, one tick per unit. It is captured only while reset is held, so a new value written later has no effect until the next reset. The state machine has three states. IDLE holds the output at zero. RAMP counts ticks and applies stages. TRACK is the done state and follows the target. The transitions are: IDLE to RAMP when the enable goes high. RAMP to TRACK on the stage that reaches the target. RAMP to IDLE and TRACK to IDLE whenever the enable drops. Reset returns the block to IDLE.

Top module: `pwr_ramp_seq`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it rises, `applied` is 0 and `done` is 0.
- R2: When `hp_en` is sampled low, `applied` is 0 and `done` is 0 from the next cycle. A later ramp starts again from stage 0.
- R3: When `hp_en` is sampled high in IDLE, the block enters RAMP on that edge. `applied` stays 0 until the first stage is applied.
- R4: Stage k, for k from 1 to 20, has level floor(k*255/20), where 255 is full scale for an 8-bit level. Each stage sets `applied` to the smaller of that level and `target`. Between stages `applied` holds steady.
- R5: In RAMP, a stage is applied on the tick that completes D ticks counted since RAMP was entered or since the previous stage, where D is the latched delay. A latched delay of 0 behaves like 1, giving one stage per tick.
- R6: The delay is taken from `dly_cfg` only while `rst_n` is low. Changes to `dly_cfg` after reset leave the stage spacing unchanged.
- R7: The stage whose level is at or above `target` moves the block to TRACK. `done` is then 1 and `applied` equals the target, and no further stages follow.
- R8: In TRACK with `hp_en` high, `applied` equals the value `target` had one cycle earlier. Target changes are followed without a new ramp.
- R9: A target of 0 completes at the first stage, with `applied` 0 and `done` 1.
- R10: If `target` drops below the applied level during a ramp, the next stage applies the new target and completes the ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; also the delay capture window |
| hp_en | input | 1 | High power enable; low forces zero power and re-arms the ramp |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| dly_cfg | input | 16 | Ticks between stages, captured during reset |
| target | input | 8 | Requested power level |
| applied | output | 8 | Power level currently applied |
| done | output | 1 | High once the ramp has reached the target |

## Verification
The bench first runs a ramp after writing a new delay without a reset. A design that sampled the delay continuously would speed up at once and drift away from the old stage spacing. Zero delay is run with a tick on every cycle. A design that compared against the raw count would either stall there or step twice per tick. A target of zero, a target cut mid-ramp and a target of full scale exercise the early finish and the twentieth stage. A design that missed the comparison would keep ramping past the target or never raise `done`. Dropping the enable in both RAMP and TRACK and then re-enabling checks that the ramp restarts from stage 0 rather than from where it left off.

// File: rtl/pwr_ramp_pkg.sv
package pwr_ramp_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RAMP  = 2'd1,
        S_TRACK = 2'd2
    } ramp_state_e;
endpackage

// File: rtl/pwr_stage_lut.sv
module pwr_stage_lut #(
    parameter int LVL_W      = 8,
    parameter int NUM_STAGES = 20,
    parameter int STG_W      = $clog2(NUM_STAGES + 1)
) (
    input  logic [STG_W-1:0] idx,
    output logic [LVL_W-1:0] level
);
    localparam int FULL    = (1 << LVL_W) - 1;
    localparam int ENTRIES = 1 << STG_W;

    logic [LVL_W-1:0] tab [ENTRIES];

    // Stage k maps to floor(k * full / stages); indices past the last stage saturate.
    for (genvar k = 0; k < ENTRIES; k++) begin : g_stage
        if (k >= NUM_STAGES) begin : g_sat
            assign tab[k] = LVL_W'(FULL);
        end else begin : g_frac
            assign tab[k] = LVL_W'((k * FULL) / NUM_STAGES);
        end
    end

    assign level = tab[idx];
endmodule

// File: rtl/pwr_gap_timer.sv
module pwr_gap_timer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DLY_W-1:0] dly_cfg,
    input  logic             us_tick,
    input  logic             run,
    output logic             step
);
    logic [DLY_W-1:0] dly_q;
    logic [DLY_W-1:0] cnt_q;
    logic [DLY_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + (DLY_W+1)'(1);
    assign step    = run && us_tick && (cnt_inc >= {1'b0, dly_q});

    // Delay capture happens only inside the reset window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q <= dly_cfg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (us_tick) begin
            cnt_q <= step ? '0 : cnt_inc[DLY_W-1:0];
        end
    end

    // R6: the captured delay never moves outside reset
    a_r6_dly_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(dly_q));

    // R5: without a tick the gap count holds
    a_r5_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !us_tick) |=> $stable(cnt_q));
endmodule

// File: rtl/pwr_ramp_seq.sv
module pwr_ramp_seq
    import pwr_ramp_pkg::*;
#(
    parameter int LVL_W      = 8,
    parameter int DLY_W      = 16,
    parameter int NUM_STAGES = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hp_en,
    input  logic             us_tick,
    input  logic [DLY_W-1:0] dly_cfg,
    input  logic [LVL_W-1:0] target,
    output logic [LVL_W-1:0] applied,
    output logic             done
);
    localparam int STG_W = $clog2(NUM_STAGES + 1);

    ramp_state_e      state_q, state_d;
    logic [STG_W-1:0] stage_q;
    logic [STG_W-1:0] nxt_idx;
    logic [LVL_W-1:0] stage_lvl;
    logic [LVL_W-1:0] step_lvl;
    logic             reach;
    logic             step;

    assign nxt_idx  = stage_q + STG_W'(1);
    assign reach    = (stage_lvl >= target);
    assign step_lvl = reach ? target : stage_lvl;

    pwr_stage_lut #(
        .LVL_W      (LVL_W),
        .NUM_STAGES (NUM_STAGES),
        .STG_W      (STG_W)
    ) u_lut (
        .idx   (nxt_idx),
        .level (stage_lvl)
    );

    pwr_gap_timer #(
        .DLY_W (DLY_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .dly_cfg (dly_cfg),
        .us_tick (us_tick),
        .run     (state_q == S_RAMP),
        .step    (step)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (hp_en) state_d = S_RAMP;
            S_RAMP: begin
                if (!hp_en)             state_d = S_IDLE;
                else if (step && reach) state_d = S_TRACK;
            end
            S_TRACK: if (!hp_en) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            applied <= '0;
            stage_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    applied <= '0;
                    stage_q <= '0;
                end
                S_RAMP: begin
                    if (!hp_en) begin
                        applied <= '0;
                        stage_q <= '0;
                    end else if (step) begin
                        applied <= step_lvl;
                        stage_q <= nxt_idx;
                    end
                end
                S_TRACK: applied <= hp_en ? target : '0;
                default: applied <= '0;
            endcase
        end
    end

    assign done = (state_q == S_TRACK);

    // R2: enable low forces zero power on the next cycle
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hp_en |=> (applied == '0));

    // R4: between stages the applied level holds
    a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RAMP && hp_en && !step) |=> $stable(applied));

    // R8: once done, output follows the target one cycle later
    a_r8_track: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TRACK && hp_en) |=> (applied == $past(target)));

    // R7: done is never raised while the output is still below its stage cap
    a_r7_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (applied == $past(target)));
endmodule

// File: tb/pwr_ramp_seq_tb.sv
module pwr_ramp_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hp_en = 1'b0;
    logic        us_tick = 1'b0;
    logic [15:0] dly_cfg = 16'd3;
    logic [7:0]  target = 8'd200;
    logic [7:0]  applied;
    logic        done;

    int checks = 0;
    int errors = 0;
    int tick_per = 2;
    int tdiv = 0;
    int cycles = 0;
    string tag = "R1";

    // reference model state
    int m_mode = 0, m_stg = 0, m_cnt = 0, m_dly = 0, m_app = 0;
    bit m_done = 0;

    always #4 clk = ~clk;

    pwr_ramp_seq u_dut (
        .clk(clk), .rst_n(rst_n), .hp_en(hp_en), .us_tick(us_tick),
        .dly_cfg(dly_cfg), .target(target), .applied(applied), .done(done)
    );

    always @(negedge clk) begin
        tdiv = (tdiv + 1) % tick_per;
        us_tick = (tdiv == 0);
    end

    always @(posedge clk) begin
        int lv;
        if (!rst_n) begin
            m_dly = dly_cfg; m_mode = 0; m_app = 0; m_stg = 0; m_cnt = 0;
        end else begin
            case (m_mode)
                0: begin
                    m_app = 0; m_stg = 0; m_cnt = 0;
                    if (hp_en) m_mode = 1;
                end
                1: begin
                    if (!hp_en) begin
                        m_mode = 0; m_app = 0; m_stg = 0; m_cnt = 0;
                    end else if (us_tick) begin
                        if (m_cnt + 1 >= m_dly) begin
                            m_stg = m_stg + 1;
                            lv = (m_stg * 255) / 20;
                            m_app = (lv < int'(target)) ? lv : int'(target);
                            if (lv >= int'(target)) m_mode = 2;
                            m_cnt = 0;
                        end else begin
                            m_cnt = m_cnt + 1;
                        end
                    end
                end
                default: begin
                    if (!hp_en) begin m_mode = 0; m_app = 0; end
                    else m_app = int'(target);
                end
            endcase
        end
        m_done = (m_mode == 2);
    end

    always @(negedge clk) begin
        cycles++;
        checks++;
        if (int'(applied) != m_app || done != m_done) begin
            errors++;
            $display("FAIL %s cycle %0d: applied=%0d done=%0d expected applied=%0d done=%0d",
                     tag, cycles, applied, done, m_app, m_done);
        end
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: run did not end");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic direct(input string req, input int exp_app, input bit exp_done);
        checks++;
        if (int'(applied) != exp_app || done != exp_done) begin
            errors++;
            $display("FAIL %s: applied=%0d done=%0d expected applied=%0d done=%0d",
                     req, applied, done, exp_app, exp_done);
        end
    endtask

    initial begin
        tag = "R1"; wait_cyc(5);
        direct("R1", 0, 0);
        @(negedge clk); rst_n = 1'b1;
        tag = "R2"; wait_cyc(10);
        direct("R2", 0, 0);
        // R6: new delay written without reset must not change spacing
        dly_cfg = 16'd0;
        hp_en = 1'b1;
        tag = "R3"; wait_cyc(3);
        direct("R3", 0, 0);
        tag = "R6"; wait_cyc(150);
        tag = "R7"; direct("R7", 200, 1);
        // R8 tracking
        tag = "R8";
        target = 8'd100; wait_cyc(5); direct("R8", 100, 1);
        target = 8'd255; wait_cyc(5);
        target = 8'd30;  wait_cyc(5); direct("R8", 30, 1);
        tag = "R2"; hp_en = 1'b0; wait_cyc(5); direct("R2", 0, 0);
        // R9 zero target
        tag = "R9"; target = 8'd0; hp_en = 1'b1; wait_cyc(30); direct("R9", 0, 1);
        // R10 target cut mid ramp, with enable drop in RAMP first
        tag = "R2"; hp_en = 1'b0; wait_cyc(2);
        target = 8'd255; hp_en = 1'b1; wait_cyc(20);
        hp_en = 1'b0; wait_cyc(2); hp_en = 1'b1;
        tag = "R10"; wait_cyc(30); target = 8'd40; wait_cyc(60);
        direct("R10", 40, 1);
        // R5: zero delay, tick every cycle, full-scale target reaches stage 20
        tag = "R5"; hp_en = 1'b0; rst_n = 1'b0; dly_cfg = 16'd0; tick_per = 1;
        wait_cyc(3); rst_n = 1'b1; target = 8'd255; hp_en = 1'b1;
        wait_cyc(6);
        tag = "R4"; wait_cyc(30); direct("R4", 255, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule